// File: doc/BRIEF.md
# Stale Data Bus Latch

This block sits beside the address decoder of a 32-bit processor bus. It remembers the value that most recently crossed the data bus. When a read targets space that nothing answers, the bus returns that remembered value instead of memory data. Every completed transfer feeds the memory: all writes, and reads that were actually decoded. Byte and halfword transfers are normally spread across the full word. Transfers into one internal RAM window behave differently. There, a separate shadow word is merged lane by lane, and the main memory then copies the shadow.

On every cycle the block presents the aligned open-bus value for the current address and size. It also flags whether the current read must take that value. The consumer multiplexes the flag and the value into its read path and masks any bits above the access width.

Top module: `stale_bus_latch`

## Requirements
- R1: A read (strobe high, write low) whose address is at or above 0x1000_0000 raises `readUsesOpen` whatever `accMapped` says, and leaves `latchWord` and `shadowWord` unchanged.
- R2: Size is encoded as 2'b00 byte, 2'b01 halfword and 2'b10 word. Every write, and every decoded read (mapped, below 0x1000_0000 and outside the hole of R9), updates the memory on the clock edge where `accValid` is high. A cycle with `accValid` low changes nothing.
- R3: A read with `accMapped` low raises `readUsesOpen` and leaves `latchWord` and `shadowWord` unchanged.
- R4: Outside the special window, a byte update loads `accData[7:0]` into all four byte lanes of `latchWord`.
- R5: Outside the special window, a halfword update loads `accData[15:0]` into both halves of `latchWord`. A word update loads `accData` unchanged.
- R6: The special window is any address whose bits 31:24 equal 0x03. An update there first changes `shadowWord`, and after the same edge `latchWord` equals the new `shadowWord`.
- R7: In the special window, a word update replaces the whole shadow. A halfword update replaces bits 31:16 when address bit 1 is set and bits 15:0 otherwise. A byte update replaces only lane `accAddr[1:0]` (lane n is bits 8n+7:8n). An update outside the window leaves `shadowWord` unchanged.
- R8: `obusData` equals `latchWord` shifted right by 8 times an aligned offset. The offset is 0 for a word, `{accAddr[1],0}` for a halfword and `accAddr[1:0]` for a byte.
- R9: A read from 0x0000_4000 up to 0x01FF_FFFF inclusive is treated as unmapped, as in R3, even when `accMapped` is high.
- R10: Reset clears `latchWord` and `shadowWord` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access completes this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSize | input | 2 | Transfer size code |
| accAddr | input | 32 | Byte address of the access |
| accData | input | 32 | Write data, or data returned by the decoded target |
| accMapped | input | 1 | Decoder found a target for this address |
| obusData | output | 32 | Aligned open-bus value for this address and size |
| readUsesOpen | output | 1 | Current read must return `obusData` |
| latchWord | output | 32 | Main open-bus memory |
| shadowWord | output | 32 | Shadow word of the special window |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, the 0x1000_0000 upper limit, the 0x0000_4000 to 0x01FF_FFFF hole and window tag 0x03. With these values the bench can reach the exact edges of each range. It probes 0x0000_3FFF against 0x0000_4000, 0x01FF_FFFF against 0x0200_0000, and 0x0FFF_FFFC against 0x1000_0000 and above. It also runs shadow sequences in which lanes written earlier must carry over through later narrow accesses. Interleaving ordinary accesses shows that the shadow survives while the main memory is overwritten elsewhere.

// File: rtl/stale_bus_pkg.sv
package stale_bus_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMirror;  // update main memory with spread data
    logic loadShadow;  // merge into shadow, then copy to main
  } bus_ctrl_t;
endpackage

// File: rtl/stale_bus_ctrl.sv
module stale_bus_ctrl
  import stale_bus_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter logic [31:0] HIGH_LIMIT = 32'h1000_0000,
  parameter logic [31:0] HOLE_LO    = 32'h0000_4000,
  parameter logic [31:0] HOLE_HI    = 32'h01FF_FFFF,
  parameter logic [7:0]  WIN_TAG    = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accMapped,
  output bus_ctrl_t         ctrl,
  output logic              readUsesOpen
);
  localparam int unsigned TAG_LO = ADDR_W - 8;

  logic aboveLimit, inHole, inWindow, isRead, decodedRead, doUpdate;

  always_comb begin
    aboveLimit  = (accAddr >= ADDR_W'(HIGH_LIMIT));
    inHole      = (accAddr >= ADDR_W'(HOLE_LO)) && (accAddr <= ADDR_W'(HOLE_HI));
    inWindow    = (accAddr[ADDR_W-1:TAG_LO] == WIN_TAG);
    isRead      = accValid && !accWrite;
    decodedRead = isRead && accMapped && !aboveLimit && !inHole;
    doUpdate    = (accValid && accWrite) || decodedRead;
    readUsesOpen    = isRead && !decodedRead;
    ctrl.loadShadow = doUpdate && inWindow;
    ctrl.loadMirror = doUpdate && !inWindow;
  end

  AST_HIGH_READ_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && accAddr >= ADDR_W'(HIGH_LIMIT)) |-> (readUsesOpen && !ctrl.loadMirror && !ctrl.loadShadow)); // R1
  AST_HOLE_READ_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && accAddr >= ADDR_W'(HOLE_LO) && accAddr <= ADDR_W'(HOLE_HI)) |-> readUsesOpen); // R9
  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.loadMirror, ctrl.loadShadow})); // R6
  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !(ctrl.loadMirror || ctrl.loadShadow)); // R2
endmodule

// File: rtl/stale_bus_dpath.sv
module stale_bus_dpath
  import stale_bus_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bus_ctrl_t               ctrl,
  input  logic [1:0]              accSize,
  input  logic [$clog2(DATA_W/8)-1:0] addrLow,
  input  logic [DATA_W-1:0]       accData,
  output logic [DATA_W-1:0]       obusData,
  output logic [DATA_W-1:0]       latchWord,
  output logic [DATA_W-1:0]       shadowWord
);
  localparam int unsigned LANES     = DATA_W / 8;
  localparam int unsigned HALVES    = LANES / 2;
  localparam int unsigned LANE_BITS = $clog2(LANES);
  localparam int unsigned HALF_W    = DATA_W / 2;

  logic [DATA_W-1:0]    byteSpread, halfSpread, mirrorNext, shadowNext, mainNext;
  logic [LANES-1:0]     laneHit;
  logic [LANE_BITS-1:0] alignOff;

  // spread narrow data across the full word
  for (genvar l = 0; l < LANES; l++) begin : g_byteSpread
    assign byteSpread[8*l +: 8] = accData[7:0];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_halfSpread
    assign halfSpread[HALF_W*h +: HALF_W] = accData[HALF_W-1:0];
  end

  always_comb begin
    unique case (accSize)
      SZ_BYTE: mirrorNext = byteSpread;
      SZ_HALF: mirrorNext = halfSpread;
      default: mirrorNext = accData;
    endcase
  end

  // lanes the shadow merge replaces
  for (genvar l = 0; l < LANES; l++) begin : g_laneHit
    always_comb begin
      unique case (accSize)
        SZ_BYTE: laneHit[l] = (addrLow == LANE_BITS'(l));
        SZ_HALF: laneHit[l] = (addrLow[LANE_BITS-1] == ((l / HALVES) != 0));
        default: laneHit[l] = 1'b1;
      endcase
    end
    // narrow data sits in the low lanes; place it on lane l
    assign shadowNext[8*l +: 8] = laneHit[l] ? mirrorNext[8*l +: 8] : shadowWord[8*l +: 8];
  end

  always_comb begin
    mainNext = latchWord;
    if (ctrl.loadShadow)      mainNext = shadowNext;
    else if (ctrl.loadMirror) mainNext = mirrorNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchWord  <= '0;
      shadowWord <= '0;
    end else begin
      latchWord <= mainNext;
      if (ctrl.loadShadow) shadowWord <= shadowNext;
    end
  end

  // aligned read offset
  always_comb begin
    unique case (accSize)
      SZ_BYTE: alignOff = addrLow;
      SZ_HALF: alignOff = {addrLow[LANE_BITS-1:1], 1'b0};
      default: alignOff = '0;
    endcase
    obusData = latchWord >> {alignOff, 3'b000};
  end

  AST_SHADOW_FEEDS_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadShadow |=> (latchWord == shadowWord)); // R6
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadShadow |=> $stable(shadowWord)); // R7
  AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.loadShadow || ctrl.loadMirror) |=> $stable(latchWord)); // R3
endmodule

// File: rtl/stale_bus_latch.sv
module stale_bus_latch
  import stale_bus_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter logic [31:0] HIGH_LIMIT = 32'h1000_0000,
  parameter logic [31:0] HOLE_LO    = 32'h0000_4000,
  parameter logic [31:0] HOLE_HI    = 32'h01FF_FFFF,
  parameter logic [7:0]  WIN_TAG    = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accData,
  input  logic              accMapped,
  output logic [DATA_W-1:0] obusData,
  output logic              readUsesOpen,
  output logic [DATA_W-1:0] latchWord,
  output logic [DATA_W-1:0] shadowWord
);
  localparam int unsigned LANES     = DATA_W / 8;
  localparam int unsigned LANE_BITS = $clog2(LANES);
  localparam int unsigned HALF_W    = DATA_W / 2;

  bus_ctrl_t ctrl;

  stale_bus_ctrl #(
    .ADDR_W(ADDR_W), .HIGH_LIMIT(HIGH_LIMIT), .HOLE_LO(HOLE_LO),
    .HOLE_HI(HOLE_HI), .WIN_TAG(WIN_TAG)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .accMapped(accMapped), .ctrl(ctrl),
    .readUsesOpen(readUsesOpen)
  );

  stale_bus_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .accSize(accSize),
    .addrLow(accAddr[LANE_BITS-1:0]), .accData(accData),
    .obusData(obusData), .latchWord(latchWord), .shadowWord(shadowWord)
  );

  logic outsideUpdate;
  assign outsideUpdate = accValid && (accAddr[ADDR_W-1:ADDR_W-8] != WIN_TAG) &&
    (accWrite || (accMapped && accAddr < ADDR_W'(HIGH_LIMIT) &&
     !(accAddr >= ADDR_W'(HOLE_LO) && accAddr <= ADDR_W'(HOLE_HI))));

  AST_BYTE_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (outsideUpdate && accSize == SZ_BYTE) |=> (latchWord == {LANES{$past(accData[7:0])}})); // R4
  AST_HALF_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (outsideUpdate && accSize == SZ_HALF) |=> (latchWord == {2{$past(accData[HALF_W-1:0])}})); // R5
  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && !accMapped) |=> ($stable(latchWord) && $stable(shadowWord))); // R3

  always_comb begin
    if (rstN && accSize == SZ_WORD)
      AST_WORD_ALIGN: assert (obusData == latchWord); // R8
  end
endmodule

// File: tb/stale_bus_latch_tb_top.sv
`timescale 1ns/1ps
module stale_bus_latch_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0, accMapped = 1'b0;
  logic [1:0]  accSize = 2'b00;
  logic [31:0] accAddr = '0, accData = '0;
  logic [31:0] obusData, latchWord, shadowWord;
  logic        readUsesOpen;
  int checks = 0, errors = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  stale_bus_latch dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSize(accSize), .accAddr(accAddr), .accData(accData),
    .accMapped(accMapped), .obusData(obusData), .readUsesOpen(readUsesOpen),
    .latchWord(latchWord), .shadowWord(shadowWord)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] data;
    logic        mapped;
    logic        expOpen;
    logic [31:0] expLatch;
    logic [31:0] expShadow;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 32'h0200_0000, 32'h1122_3344, 1'b1, 1'b0, 32'h1122_3344, 32'h0, 4'd2},  // R2 word write
    '{1'b0, 2'd0, 32'h0800_0001, 32'hAABB_CCA5, 1'b1, 1'b0, 32'hA5A5_A5A5, 32'h0, 4'd4},  // R4
    '{1'b0, 2'd1, 32'h0600_0002, 32'h0000_BEEF, 1'b1, 1'b0, 32'hBEEF_BEEF, 32'h0, 4'd5},  // R5
    '{1'b0, 2'd2, 32'h0400_0000, 32'hDEAD_DEAD, 1'b0, 1'b1, 32'hBEEF_BEEF, 32'h0, 4'd3},  // R3
    '{1'b0, 2'd0, 32'h1000_0003, 32'h1234_5678, 1'b1, 1'b1, 32'hBEEF_BEEF, 32'h0, 4'd1},  // R1
    '{1'b0, 2'd1, 32'h0000_5003, 32'h1234_5678, 1'b1, 1'b1, 32'hBEEF_BEEF, 32'h0, 4'd9},  // R9
    '{1'b1, 2'd0, 32'h0300_0002, 32'h0000_00C3, 1'b1, 1'b0, 32'h00C3_0000, 32'h00C3_0000, 4'd7}, // R7 byte lane 2
    '{1'b0, 2'd1, 32'h0300_1002, 32'h0000_7E57, 1'b1, 1'b0, 32'h7E57_0000, 32'h7E57_0000, 4'd7}, // R7 upper half
    '{1'b1, 2'd1, 32'h0300_0000, 32'hFFFF_1234, 1'b0, 1'b0, 32'h7E57_1234, 32'h7E57_1234, 4'd7}, // R7 lower half
    '{1'b1, 2'd0, 32'h0300_0001, 32'h0000_009A, 1'b1, 1'b0, 32'h7E57_9A34, 32'h7E57_9A34, 4'd6}, // R6
    '{1'b1, 2'd2, 32'h0200_0010, 32'h0F0F_0F0F, 1'b1, 1'b0, 32'h0F0F_0F0F, 32'h7E57_9A34, 4'd7}, // R7 shadow kept
    '{1'b0, 2'd0, 32'h0300_0003, 32'h0000_0055, 1'b1, 1'b0, 32'h5557_9A34, 32'h5557_9A34, 4'd6}, // R6 carry-over
    '{1'b1, 2'd1, 32'h1200_0002, 32'h0000_4321, 1'b0, 1'b0, 32'h4321_4321, 32'h5557_9A34, 4'd2}, // R2 high write
    '{1'b0, 2'd2, 32'h0300_0000, 32'h9999_9999, 1'b0, 1'b1, 32'h4321_4321, 32'h5557_9A34, 4'd3}, // R3 window unmapped
    '{1'b0, 2'd2, 32'h0000_0000, 32'hCAFE_F00D, 1'b1, 1'b0, 32'hCAFE_F00D, 32'h5557_9A34, 4'd2}, // R2
    '{1'b0, 2'd0, 32'h0000_3FFF, 32'h0000_0077, 1'b1, 1'b0, 32'h7777_7777, 32'h5557_9A34, 4'd9}, // R9 below hole
    '{1'b0, 2'd0, 32'h0200_0000, 32'h0000_0088, 1'b1, 1'b0, 32'h8888_8888, 32'h5557_9A34, 4'd9}, // R9 above hole
    '{1'b0, 2'd2, 32'h0FFF_FFFC, 32'h0102_0304, 1'b1, 1'b0, 32'h0102_0304, 32'h5557_9A34, 4'd1}, // R1 below limit
    '{1'b0, 2'd0, 32'h0000_4000, 32'h0000_00EE, 1'b1, 1'b1, 32'h0102_0304, 32'h5557_9A34, 4'd9}, // R9 hole start
    '{1'b0, 2'd1, 32'h01FF_FFFF, 32'h0000_EEEE, 1'b1, 1'b1, 32'h0102_0304, 32'h5557_9A34, 4'd8}  // R8 half align
  };

  // R8 expected aligned value
  function automatic logic [31:0] alignedOf(logic [31:0] mem, logic [1:0] sz, logic [1:0] lo);
    logic [1:0] off;
    off = (sz == 2'd2) ? 2'd0 : (sz == 2'd1) ? {lo[1], 1'b0} : lo;
    return mem >> (8 * off);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic v, logic w, logic [1:0] s, logic [31:0] a, logic [31:0] d, logic m);
    accValid = v; accWrite = w; accSize = s; accAddr = a; accData = d; accMapped = m;
  endtask

  initial begin : main
    logic [31:0] prevLatch;
    @(negedge clk); @(negedge clk);
    check("R10 reset latch", latchWord, 32'h0);
    check("R10 reset shadow", shadowWord, 32'h0);
    rstN = 1'b1;
    prevLatch = 32'h0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(1'b1, VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].data, VECS[i].mapped);
      #1;
      check($sformatf("R%0d vec %0d open flag", VECS[i].req, i), {31'b0, readUsesOpen}, {31'b0, VECS[i].expOpen});
      if (VECS[i].expOpen)
        check($sformatf("R8 vec %0d obus", i), obusData, alignedOf(prevLatch, VECS[i].sz, VECS[i].addr[1:0]));
      @(posedge clk); #1;
      check($sformatf("R%0d vec %0d latch", VECS[i].req, i), latchWord, VECS[i].expLatch);
      check($sformatf("R%0d vec %0d shadow", VECS[i].req, i), shadowWord, VECS[i].expShadow);
      prevLatch = VECS[i].expLatch;
    end

    // R8 byte and word alignment on the settled value 0x01020304
    @(negedge clk);
    drive(1'b0, 1'b0, 2'd0, 32'h0000_0002, 32'h0, 1'b0); #1;
    check("R8 byte lane2", obusData, 32'h0000_0102);
    drive(1'b0, 1'b0, 2'd2, 32'h0000_0003, 32'h0, 1'b0); #1;
    check("R8 word ignores low bits", obusData, 32'h0102_0304);

    // R2 idle cycle with busy inputs changes nothing
    drive(1'b0, 1'b1, 2'd0, 32'h0300_0000, 32'hFFFF_FFFF, 1'b1);
    @(posedge clk); #1;
    check("R2 idle latch", latchWord, 32'h0102_0304);
    check("R2 idle shadow", shadowWord, 32'h5557_9A34);

    // R10 reset mid-run
    @(negedge clk);
    drive(1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
    rstN = 1'b0; #1;
    check("R10 mid reset latch", latchWord, 32'h0);
    check("R10 mid reset shadow", shadowWord, 32'h0);
    @(negedge clk); rstN = 1'b1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule